// File: doc/BRIEF.md
# ADC Status Flags and Window Watchdog

This block sits beside an ADC sequencer and turns its conversion-complete strobes into sticky status flags and one interrupt line. Each completed conversion arrives as a one-cycle strobe. The strobe carries the group it belongs to (regular or inserted), whether it closes the inserted group, a 5-bit channel number and the result value. The block checks every result against a programmable window and raises a watchdog flag when the value falls outside it. Watchdog checking is enabled separately for each group, and a single-channel mode restricts it to one chosen channel.

Software reaches four word-wide registers over a simple synchronous bus: status, control, low threshold and high threshold. Status flags are cleared by writing 0 to their bit. The conversion-done flag also clears when the sequencer reports a read of the result data register. The interrupt output is the OR of every flag that has its enable bit set.

Top module: `adc_flag_ctrl`

## Requirements
- R1: After reset, status reads 0, control reads 0, the low threshold reads 0, the high threshold reads all ones (0xFFF for 12-bit data) and `irq` is 0.
- R2: Control sits at offset 0x04. Its writable fields are: overrun interrupt enable at bit 26, regular-group watchdog enable at bit 23, inserted-group watchdog enable at bit 22, single-channel mode at bit 9, group-done interrupt enable at bit 7, watchdog interrupt enable at bit 6, conversion-done interrupt enable at bit 5, and channel select at bits 4:0. All other bits read 0, so writing all ones reads back 0x04C002FF.
- R3: Any completed conversion, regular or inserted, sets the conversion-done flag (status bit 1) on the following cycle.
- R4: The conversion-done flag is cleared by a status write with bit 1 at 0, or by a `data_rd` strobe. Writing 1 to any status bit leaves that bit unchanged.
- R5: The group-done flag (status bit 2) is set only by an inserted conversion that has `conv_last` high. It is cleared by writing 0 to bit 2.
- R6: The watchdog flag (status bit 0) is set when a result is below the low threshold or above the high threshold, and the group's watchdog enable is 1. A value equal to either threshold is inside the window. A conversion of a group whose enable is 0 never sets the flag.
- R7: With single-channel mode set, only conversions whose channel equals the channel select can set the watchdog flag. With the mode clear, every channel of an enabled group is checked.
- R8: The overrun flag (status bit 3) is set when a regular conversion completes while the conversion-done flag is already set. Inserted conversions never set it. It is cleared by writing 0 to bit 3.
- R9: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is high whenever some status flag is set together with its enable bit, and it stays high until that flag is cleared or the enable is removed.
- R11: The low threshold is at 0x08 and the high threshold is at 0x0C, each DATA_W bits wide with the upper bits reading 0. Status is at 0x00. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion has completed |
| conv_inserted | input | 1 | 1 = inserted group, 0 = regular group |
| conv_last | input | 1 | Conversion closes the inserted group |
| conv_chan | input | 5 | Channel number of the conversion |
| conv_data | input | DATA_W | Conversion result |
| data_rd | input | 1 | Strobe: result data register was read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several properties on every cycle. It checks that each conversion sets the done flag and that a regular conversion onto a pending done flag raises overrun. It checks that a read strobe clears the done flag, that the group-done and watchdog flags only rise right after a conversion, and that `irq` stays low while no flag is set. The directed scenarios cover what needs register context: the window edges and the per-group enables, single-channel matching, the bit layout of control and the thresholds, write-1 having no effect, and the race between a hardware set and a software clear.

// File: rtl/adc_flag_pkg.sv
// Package: shared constants and types for the ADC status/watchdog block.
// Assumes a 32-bit register bus and a fixed 5-bit channel field.
package adc_flag_pkg;

    localparam int BUS_W     = 32;
    localparam int CHAN_W    = 5;
    localparam int NUM_FLAGS = 4;

    // Register byte offsets
    localparam int OFS_STAT = 'h00;
    localparam int OFS_CTRL = 'h04;
    localparam int OFS_WLO  = 'h08;
    localparam int OFS_WHI  = 'h0C;

    // Status bit positions
    localparam int FLG_WD    = 0;
    localparam int FLG_DONE  = 1;
    localparam int FLG_GDONE = 2;
    localparam int FLG_OVR   = 3;

    // Control bit positions
    localparam int CB_OVR_IE   = 26;
    localparam int CB_REG_WEN  = 23;
    localparam int CB_INS_WEN  = 22;
    localparam int CB_SINGLE   = 9;
    localparam int CB_GDONE_IE = 7;
    localparam int CB_WD_IE    = 6;
    localparam int CB_DONE_IE  = 5;

    localparam logic [BUS_W-1:0] CTRL_MASK = 32'h04C0_02FF;

    typedef struct packed {
        logic              ovr_ie;
        logic              reg_wen;
        logic              ins_wen;
        logic              single;
        logic              gdone_ie;
        logic              wd_ie;
        logic              done_ie;
        logic [CHAN_W-1:0] chan_sel;
    } ctrl_t;

endpackage

// File: rtl/adc_flag_regs.sv
// Module: register file for control and thresholds, plus the read mux.
// Assumes writes are full 32-bit words; a status write yields a per-bit
// clear vector (bits written 0) for the flag module and stores nothing here.
module adc_flag_regs
    import adc_flag_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [BUS_W-1:0]     bus_wdata,
    input  logic [NUM_FLAGS-1:0] flags_i,
    output logic [BUS_W-1:0]     bus_rdata,
    output ctrl_t                ctrl_o,
    output logic [DATA_W-1:0]    wlo_o,
    output logic [DATA_W-1:0]    whi_o,
    output logic [NUM_FLAGS-1:0] stat_clr_o
);

    localparam int PAD_D = BUS_W - DATA_W;
    localparam int PAD_F = BUS_W - NUM_FLAGS;

    logic [BUS_W-1:0]  ctrl_q;
    logic [DATA_W-1:0] wlo_q;
    logic [DATA_W-1:0] whi_q;
    logic sel_stat, sel_ctrl, sel_wlo, sel_whi;

    // Address decode
    always_comb begin
        sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
        sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_wlo  = (bus_addr == ADDR_W'(OFS_WLO));
        sel_whi  = (bus_addr == ADDR_W'(OFS_WHI));
    end

    // Register writes; reserved control bits are masked off at the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            wlo_q  <= '0;
            whi_q  <= '1;
        end else if (bus_wr) begin
            if (sel_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (sel_wlo)  wlo_q  <= bus_wdata[DATA_W-1:0];
            if (sel_whi)  whi_q  <= bus_wdata[DATA_W-1:0];
        end
    end

    // Status write produces clear requests for bits written as 0
    always_comb begin
        stat_clr_o = (bus_wr && sel_stat) ? ~bus_wdata[NUM_FLAGS-1:0] : '0;
    end

    // Read mux
    always_comb begin
        if (sel_stat)      bus_rdata = {{PAD_F{1'b0}}, flags_i};
        else if (sel_ctrl) bus_rdata = ctrl_q;
        else if (sel_wlo)  bus_rdata = {{PAD_D{1'b0}}, wlo_q};
        else if (sel_whi)  bus_rdata = {{PAD_D{1'b0}}, whi_q};
        else               bus_rdata = '0;
    end

    // Unpack control fields
    always_comb begin
        ctrl_o.ovr_ie   = ctrl_q[CB_OVR_IE];
        ctrl_o.reg_wen  = ctrl_q[CB_REG_WEN];
        ctrl_o.ins_wen  = ctrl_q[CB_INS_WEN];
        ctrl_o.single   = ctrl_q[CB_SINGLE];
        ctrl_o.gdone_ie = ctrl_q[CB_GDONE_IE];
        ctrl_o.wd_ie    = ctrl_q[CB_WD_IE];
        ctrl_o.done_ie  = ctrl_q[CB_DONE_IE];
        ctrl_o.chan_sel = ctrl_q[CHAN_W-1:0];
    end

    assign wlo_o = wlo_q;
    assign whi_o = whi_q;

endmodule

// File: rtl/adc_flag_wdog.sv
// Module: window comparator with group and channel qualification.
// Assumes unsigned results; values equal to a threshold are inside the window.
module adc_flag_wdog
    import adc_flag_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              conv_valid,
    input  logic              conv_inserted,
    input  logic [CHAN_W-1:0] conv_chan,
    input  logic [DATA_W-1:0] conv_data,
    input  ctrl_t             ctrl_i,
    input  logic [DATA_W-1:0] wlo_i,
    input  logic [DATA_W-1:0] whi_i,
    output logic              hit_o
);

    logic grp_en;
    logic chan_ok;
    logic outside;

    // Qualify group, channel and window, then combine
    always_comb begin
        grp_en  = conv_inserted ? ctrl_i.ins_wen : ctrl_i.reg_wen;
        chan_ok = !ctrl_i.single || (conv_chan == ctrl_i.chan_sel);
        outside = (conv_data < wlo_i) || (conv_data > whi_i);
        hit_o   = conv_valid && grp_en && chan_ok && outside;
    end

endmodule

// File: rtl/adc_flag_status.sv
// Module: bank of sticky flags; a set request overrides a clear request.
// Assumes set and clear are single-cycle requests.
module adc_flag_status #(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] flag_o
);

    for (genvar i = 0; i < NUM; i++) begin : g_flag
        logic q;
        // One sticky bit: set has priority, clear otherwise, else hold
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
        end
        assign flag_o[i] = q;
    end

endmodule

// File: rtl/adc_flag_ctrl.sv
// Module: top of the ADC status/watchdog block. Builds the flag set and
// clear requests from conversion strobes, the bus and the data-read strobe,
// and forms the combined interrupt. Assumes one conversion per cycle at most.
module adc_flag_ctrl
    import adc_flag_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic              conv_inserted,
    input  logic              conv_last,
    input  logic [4:0]        conv_chan,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              data_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    ctrl_t                ctrl;
    logic [DATA_W-1:0]    wlo;
    logic [DATA_W-1:0]    whi;
    logic [NUM_FLAGS-1:0] stat_clr;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] flag_en;
    logic                 wd_hit;

    adc_flag_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .flags_i    (flag_q),
        .bus_rdata  (bus_rdata),
        .ctrl_o     (ctrl),
        .wlo_o      (wlo),
        .whi_o      (whi),
        .stat_clr_o (stat_clr)
    );

    adc_flag_wdog #(.DATA_W(DATA_W)) u_wdog (
        .conv_valid    (conv_valid),
        .conv_inserted (conv_inserted),
        .conv_chan     (conv_chan),
        .conv_data     (conv_data),
        .ctrl_i        (ctrl),
        .wlo_i         (wlo),
        .whi_i         (whi),
        .hit_o         (wd_hit)
    );

    // Hardware set requests per flag
    always_comb begin
        flag_set            = '0;
        flag_set[FLG_WD]    = wd_hit;
        flag_set[FLG_DONE]  = conv_valid;
        flag_set[FLG_GDONE] = conv_valid && conv_inserted && conv_last;
        flag_set[FLG_OVR]   = conv_valid && !conv_inserted && flag_q[FLG_DONE];
    end

    // Clear requests: bus writes of 0, plus data read for the done flag
    always_comb begin
        flag_clr           = stat_clr;
        flag_clr[FLG_DONE] = stat_clr[FLG_DONE] || data_rd;
    end

    adc_flag_status #(.NUM(NUM_FLAGS)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    // Interrupt enables aligned to flag positions, then combined
    always_comb begin
        flag_en            = '0;
        flag_en[FLG_WD]    = ctrl.wd_ie;
        flag_en[FLG_DONE]  = ctrl.done_ie;
        flag_en[FLG_GDONE] = ctrl.gdone_ie;
        flag_en[FLG_OVR]   = ctrl.ovr_ie;
        irq                = |(flag_q & flag_en);
    end

endmodule

// File: rtl/adc_flag_ctrl_chk.sv
// Module: assertion checker for adc_flag_ctrl, attached by bind below.
// Assumes the flag vector layout from adc_flag_pkg.
module adc_flag_ctrl_chk
    import adc_flag_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 conv_valid,
    input logic                 conv_inserted,
    input logic                 conv_last,
    input logic                 data_rd,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 irq
);

    // R3
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> flags[FLG_DONE]);

    // R4
    done_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_DONE] && data_rd && !conv_valid) |=> !flags[FLG_DONE]);

    // R5
    gdone_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_GDONE]) |-> $past(conv_valid && conv_inserted && conv_last));

    // R6
    wd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_WD]) |-> $past(conv_valid));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !conv_inserted && flags[FLG_DONE]) |=> flags[FLG_OVR]);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);

endmodule

bind adc_flag_ctrl adc_flag_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .conv_valid    (conv_valid),
    .conv_inserted (conv_inserted),
    .conv_last     (conv_last),
    .data_rd       (data_rd),
    .flags         (flag_q),
    .irq           (irq)
);

// File: tb/tb_adc_flag_ctrl.sv
// Directed bench for adc_flag_ctrl: one task per scenario, each self-checking.
module tb_adc_flag_ctrl;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 12;

    localparam logic [31:0] C_OVR_IE   = 32'h0400_0000;
    localparam logic [31:0] C_REG_WEN  = 32'h0080_0000;
    localparam logic [31:0] C_INS_WEN  = 32'h0040_0000;
    localparam logic [31:0] C_SINGLE   = 32'h0000_0200;
    localparam logic [31:0] C_GDONE_IE = 32'h0000_0080;
    localparam logic [31:0] C_WD_IE    = 32'h0000_0040;
    localparam logic [31:0] C_DONE_IE  = 32'h0000_0020;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              conv_valid = 1'b0;
    logic              conv_inserted = 1'b0;
    logic              conv_last = 1'b0;
    logic [4:0]        conv_chan = '0;
    logic [DATA_W-1:0] conv_data = '0;
    logic              data_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    adc_flag_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
        .conv_inserted(conv_inserted), .conv_last(conv_last),
        .conv_chan(conv_chan), .conv_data(conv_data), .data_rd(data_rd),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic conv(input logic ins, input logic last, input logic [4:0] ch,
                        input logic [DATA_W-1:0] d);
        @(negedge clk);
        conv_valid = 1'b1; conv_inserted = ins; conv_last = last;
        conv_chan = ch; conv_data = d;
        @(negedge clk);
        conv_valid = 1'b0; conv_inserted = 1'b0; conv_last = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R1 status", v, 32'h0);
        rd(8'h04, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h08, v); chk("R1 low", v, 32'h0);
        rd(8'h0C, v); chk("R1 high", v, 32'hFFF);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R2 ctrl layout", v, 32'h04C0_02FF);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'hFFFF_F123);
        rd(8'h08, v); chk("R11 low width", v, 32'h123);
        wr(8'h0C, 32'hABCD_E456);
        rd(8'h0C, v); chk("R11 high width", v, 32'h456);
        rd(8'h10, v); chk("R11 unmapped", v, 32'h0);
        wr(8'h08, 32'h0); wr(8'h0C, 32'hFFF);
    endtask

    task automatic t_done();
        logic [31:0] v;
        conv(1'b0, 1'b0, 5'd1, 12'd10);
        rd(8'h00, v); chk("R3 regular sets done", v, 32'h2);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R4 write 1 no effect", v, 32'h2);
        pulse_rd();
        rd(8'h00, v); chk("R4 data read clears", v, 32'h0);
        conv(1'b1, 1'b0, 5'd2, 12'd10);
        rd(8'h00, v); chk("R3 inserted sets done", v, 32'h2);
        wr(8'h00, 32'hFFFF_FFFD);
        rd(8'h00, v); chk("R4 write 0 clears", v, 32'h0);
    endtask

    task automatic t_gdone();
        logic [31:0] v;
        conv(1'b1, 1'b0, 5'd3, 12'd5);
        rd(8'h00, v); chk("R5 not last", v, 32'h2);
        conv(1'b0, 1'b1, 5'd3, 12'd5);
        rd(8'h00, v); chk("R5 regular last ignored", v & 32'h4, 32'h0);
        wr(8'h00, 32'h0);
        conv(1'b1, 1'b1, 5'd3, 12'd5);
        rd(8'h00, v); chk("R5 inserted last sets", v, 32'h6);
        wr(8'h00, 32'hFFFF_FFFB);
        rd(8'h00, v); chk("R5 write 0 clears", v, 32'h2);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_wdog();
        logic [31:0] v;
        wr(8'h08, 32'd100); wr(8'h0C, 32'd200);
        conv(1'b0, 1'b0, 5'd0, 12'd50);
        rd(8'h00, v); chk("R6 both disabled", v & 32'h1, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h04, C_REG_WEN);
        conv(1'b1, 1'b0, 5'd0, 12'd50);
        rd(8'h00, v); chk("R6 inserted disabled", v & 32'h1, 32'h0);
        wr(8'h00, 32'h0);
        conv(1'b0, 1'b0, 5'd0, 12'd150);
        rd(8'h00, v); chk("R6 inside window", v & 32'h1, 32'h0);
        wr(8'h00, 32'h0);
        conv(1'b0, 1'b0, 5'd0, 12'd100);
        rd(8'h00, v); chk("R6 equal low inside", v & 32'h1, 32'h0);
        wr(8'h00, 32'h0);
        conv(1'b0, 1'b0, 5'd0, 12'd200);
        rd(8'h00, v); chk("R6 equal high inside", v & 32'h1, 32'h0);
        wr(8'h00, 32'h0);
        conv(1'b0, 1'b0, 5'd0, 12'd99);
        rd(8'h00, v); chk("R6 below low", v & 32'h1, 32'h1);
        wr(8'h00, 32'h0);
        conv(1'b0, 1'b0, 5'd0, 12'd201);
        rd(8'h00, v); chk("R6 above high", v & 32'h1, 32'h1);
        wr(8'h00, 32'hFFFF_FFFE);
        rd(8'h00, v); chk("R6 write 0 clears", v & 32'h1, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h04, C_INS_WEN);
        conv(1'b1, 1'b0, 5'd0, 12'd201);
        rd(8'h00, v); chk("R6 inserted enabled", v & 32'h1, 32'h1);
        wr(8'h00, 32'h0);
        conv(1'b0, 1'b0, 5'd0, 12'd300);
        rd(8'h00, v); chk("R6 regular disabled", v & 32'h1, 32'h0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr(8'h04, C_REG_WEN | C_SINGLE | 32'd7);
        conv(1'b0, 1'b0, 5'd3, 12'd250);
        rd(8'h00, v); chk("R7 other channel ignored", v & 32'h1, 32'h0);
        wr(8'h00, 32'h0);
        conv(1'b0, 1'b0, 5'd7, 12'd250);
        rd(8'h00, v); chk("R7 selected channel", v & 32'h1, 32'h1);
        wr(8'h00, 32'h0);
        wr(8'h04, C_REG_WEN | 32'd7);
        conv(1'b0, 1'b0, 5'd3, 12'd250);
        rd(8'h00, v); chk("R7 all channels", v & 32'h1, 32'h1);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        conv(1'b0, 1'b0, 5'd0, 12'd10);
        conv(1'b1, 1'b0, 5'd0, 12'd10);
        rd(8'h00, v); chk("R8 inserted no overrun", v, 32'h2);
        conv(1'b0, 1'b0, 5'd0, 12'd10);
        rd(8'h00, v); chk("R8 regular overrun", v, 32'hA);
        wr(8'h00, 32'hFFFF_FFF7);
        rd(8'h00, v); chk("R8 write 0 clears", v, 32'h2);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        conv(1'b0, 1'b0, 5'd0, 12'd10);
        @(negedge clk);
        conv_valid = 1'b1; conv_inserted = 1'b0; conv_data = 12'd10;
        bus_addr = 8'h00; bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0; bus_wr = 1'b0;
        rd(8'h00, v); chk("R9 set beats clear", v, 32'hA);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(8'h04, C_DONE_IE);
        conv(1'b0, 1'b0, 5'd0, 12'd10);
        chk("R10 done irq", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R10 irq held", {31'b0, irq}, 32'h1);
        pulse_rd();
        chk("R10 irq drops", {31'b0, irq}, 32'h0);
        wr(8'h04, C_WD_IE);
        conv(1'b0, 1'b0, 5'd0, 12'd10);
        chk("R10 masked flag", {31'b0, irq}, 32'h0);
        wr(8'h04, C_OVR_IE);
        conv(1'b0, 1'b0, 5'd0, 12'd10);
        chk("R10 overrun irq", {31'b0, irq}, 32'h1);
        wr(8'h04, C_GDONE_IE);
        chk("R10 enable removed", {31'b0, irq}, 32'h0);
        conv(1'b1, 1'b1, 5'd0, 12'd10);
        chk("R10 group irq", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0);
        chk("R10 cleared", {31'b0, irq}, 32'h0);
        rd(8'h00, v); chk("R10 status empty", v, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_done();
        t_gdone();
        t_wdog();
        t_single();
        t_overrun();
        t_race();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule